// File: doc/BRIEF.md
# Receiver Interrupt Collector

This block gathers one-cycle event pulses from three groups of receiver sources into one active-high interrupt line. The groups are the per-channel power meters, the receive-input power meters and the converter overflow pins. Every source has a sticky status bit that the host reads back and clears by writing ones. Every source also has a mask bit, which keeps that source from driving the interrupt line but still lets its status bit latch. So the host can poll a source that is masked.

The host reaches the block through a small write port. One address loads the mask, one clears status bits, and one holds two control bits. The first control bit is a hold-clear: while it is set, all status is forced to zero and the line stays low. The second is a float control: while it is set, the interrupt pin and the sync output are released to high impedance. A three-state machine drives the pin. PS_IDLE is the low state with nothing pending. PS_ASSERT is the high state. PS_HOLD is the state forced by the hold-clear bit. The transitions are:
- PS_IDLE to PS_ASSERT on pending.
- PS_ASSERT to PS_IDLE when nothing is pending.
- PS_IDLE or PS_ASSERT to PS_HOLD on hold.
- PS_HOLD to PS_ASSERT or PS_IDLE when hold is released, depending on whether anything is pending.

Top module: `rx_irq_collector`

## Requirements
- R1: After reset, all status bits are 0, the mask is all ones, both control bits are 0, the interrupt pin is low and `pins_oe` is 1.
- R2: An event pulse sets its status bit at the next clock edge, and the bit stays set in later cycles until it is cleared.
- R3: Status, mask and clear bits share one layout: channel meters in bits [N_CHAN-1:0], input meters next, then overflow pins in the top bits.
- R4: A write to address 1 clears each status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: When an event and a clear hit the same bit in the same cycle, the bit ends set.
- R6: A status bit latches its event even while the source's mask bit is 1.
- R7: The interrupt pin equals the OR over all bits of status AND NOT mask, taken one clock after the status or mask change.
- R8: A source whose mask bit (address 0) is 1 never raises the pin.
- R9: Writing address 2 with bit 0 set clears all status at that edge. While that bit stays 1, status remains 0, events are ignored and the pin is low.
- R10: Writing address 2 with bit 1 set drives `pins_oe` to 0 and floats `irq_pin` and `sync_out`. When bit 1 is 0, `sync_out` follows `sync_src`.
- R11: A write to address 3 changes no mask, control or status bit.
- R12: When hold is released, the pin stays low until a new unmasked event is latched, and then it rises one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 status clear, 2 control, 3 spare |
| wr_data | input | N_CHAN+N_RXPM+N_OVR | Write data |
| chan_evt | input | N_CHAN | Channel power meter event pulses |
| rxpm_evt | input | N_RXPM | Input power meter event pulses |
| ovr_evt | input | N_OVR | Overflow pin event pulses |
| sync_src | input | 1 | Internal sync to be driven on sync_out |
| status_o | output | N_CHAN+N_RXPM+N_OVR | Sticky status readback |
| mask_o | output | N_CHAN+N_RXPM+N_OVR | Mask readback |
| ctrl_o | output | 2 | Control readback: bit 0 hold, bit 1 float |
| irq_pin | output | 1 | Interrupt line, active high, three-state |
| sync_out | output | 1 | Sync output, three-state |
| pins_oe | output | 1 | Output enable shared by both pins |

## Verification
The hardest case to reach is a status bit that is cleared and set in the same edge. The bench gets there by driving an event pulse and a write-one-to-clear to the same bit in one cycle, and in the same cycle clearing a neighbouring bit to show the clear still works there. The hold-clear window is also hard to observe, because the pin would otherwise stay high for one cycle after the hold write. The bench enters hold with an unmasked source already pending, then samples status and the pin in the very first cycle after the write.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ASSERT = 2'd1,
        PS_HOLD   = 2'd2
    } pin_state_e;

    typedef enum logic [1:0] {
        ADDR_MASK  = 2'd0,
        ADDR_CLEAR = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    localparam int CTRL_HOLD_BIT  = 0;
    localparam int CTRL_FLOAT_BIT = 1;
    localparam int CTRL_W         = 2;

endpackage

// File: rtl/rx_irq_cfg.sv
module rx_irq_cfg
    import rx_irq_pkg::*;
#(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [N_SRC-1:0] wr_data,
    output logic [N_SRC-1:0] mask_q,
    output logic             hold_q,
    output logic             float_q,
    output logic [N_SRC-1:0] clr_bits,
    output logic             hold_wr
);

    logic sel_mask;
    logic sel_clear;
    logic sel_ctrl;

    always_comb begin
        sel_mask  = wr_en && (reg_addr_e'(wr_addr) == ADDR_MASK);
        sel_clear = wr_en && (reg_addr_e'(wr_addr) == ADDR_CLEAR);
        sel_ctrl  = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    end

    // Clear strobes exist only in the write cycle.
    always_comb begin
        clr_bits = sel_clear ? wr_data : '0;
        hold_wr  = sel_ctrl && wr_data[CTRL_HOLD_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (sel_mask) begin
            mask_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            float_q <= 1'b0;
        end else if (sel_ctrl) begin
            hold_q  <= wr_data[CTRL_HOLD_BIT];
            float_q <= wr_data[CTRL_FLOAT_BIT];
        end
    end

endmodule

// File: rtl/rx_irq_capture.sv
module rx_irq_capture #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] clr_bits,
    input  logic             clr_all,
    input  logic             hold_q,
    output logic [N_SRC-1:0] status_q
);

    // One sticky cell per source; the event takes priority over the clear.
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (clr_all) begin
                status_q[i] <= 1'b0;
            end else if (evt[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_bits[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (status_q == '0));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((status_q & $past(status_q & ~clr_bits)) == $past(status_q & ~clr_bits)));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && (|evt)) |=> ((status_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/rx_irq_pin_fsm.sv
module rx_irq_pin_fsm
    import rx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic hold,
    output logic irq_level
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (hold)         state_d = PS_HOLD;
                else if (pending) state_d = PS_ASSERT;
            end
            PS_ASSERT: begin
                if (hold)          state_d = PS_HOLD;
                else if (!pending) state_d = PS_IDLE;
            end
            PS_HOLD: begin
                if (!hold) state_d = pending ? PS_ASSERT : PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Output process: registered level, gated low during the hold window.
    always_comb begin
        irq_level = (state_q == PS_ASSERT) && !hold;
    end

    assert_pending_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !hold) |=> (state_q == PS_ASSERT));

    assert_hold_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == PS_HOLD));

endmodule

// File: rtl/rx_irq_collector.sv
module rx_irq_collector
    import rx_irq_pkg::*;
#(
    parameter int N_CHAN = 8,
    parameter int N_RXPM = 4,
    parameter int N_OVR  = 2,
    localparam int N_SRC = N_CHAN + N_RXPM + N_OVR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [N_SRC-1:0]  wr_data,
    input  logic [N_CHAN-1:0] chan_evt,
    input  logic [N_RXPM-1:0] rxpm_evt,
    input  logic [N_OVR-1:0]  ovr_evt,
    input  logic              sync_src,
    output logic [N_SRC-1:0]  status_o,
    output logic [N_SRC-1:0]  mask_o,
    output logic [1:0]        ctrl_o,
    output wire               irq_pin,
    output wire               sync_out,
    output logic              pins_oe
);

    logic [N_SRC-1:0] evt_all;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] clr_bits;
    logic [N_SRC-1:0] status_q;
    logic             hold_q;
    logic             float_q;
    logic             hold_wr;
    logic             clr_all;
    logic             pending;
    logic             irq_level;

    always_comb begin
        evt_all = {ovr_evt, rxpm_evt, chan_evt};
        clr_all = hold_q || hold_wr;
        pending = |(status_q & ~mask_q);
    end

    rx_irq_cfg #(.N_SRC(N_SRC)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mask_q   (mask_q),
        .hold_q   (hold_q),
        .float_q  (float_q),
        .clr_bits (clr_bits),
        .hold_wr  (hold_wr)
    );

    rx_irq_capture #(.N_SRC(N_SRC)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_all),
        .clr_bits (clr_bits),
        .clr_all  (clr_all),
        .hold_q   (hold_q),
        .status_q (status_q)
    );

    rx_irq_pin_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .hold      (hold_q),
        .irq_level (irq_level)
    );

    always_comb begin
        status_o = status_q;
        mask_o   = mask_q;
        ctrl_o   = {float_q, hold_q};
        pins_oe  = !float_q;
    end

    assign irq_pin  = pins_oe ? irq_level : 1'bz;
    assign sync_out = pins_oe ? sync_src  : 1'bz;

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> !irq_level);

    assert_float_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        float_q |-> !pins_oe);

endmodule

// File: tb/test_rx_irq_collector.sv
`timescale 1ns/1ps
module test_rx_irq_collector;

    localparam int NC = 8;
    localparam int NR = 4;
    localparam int NO = 2;
    localparam int NS = NC + NR + NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [NS-1:0] wr_data = '0;
    logic [NS-1:0] evt = '0;
    logic          sync_src = 1'b0;
    logic [NS-1:0] status_o;
    logic [NS-1:0] mask_o;
    logic [1:0]    ctrl_o;
    wire           irq_pin;
    wire           sync_out;
    logic          pins_oe;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rx_irq_collector #(.N_CHAN(NC), .N_RXPM(NR), .N_OVR(NO)) i_rx_irq_collector (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .chan_evt (evt[NC-1:0]),
        .rxpm_evt (evt[NC+NR-1:NC]),
        .ovr_evt  (evt[NS-1:NC+NR]),
        .sync_src (sync_src),
        .status_o (status_o),
        .mask_o   (mask_o),
        .ctrl_o   (ctrl_o),
        .irq_pin  (irq_pin),
        .sync_out (sync_out),
        .pins_oe  (pins_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] v);
        evt = v;
        tick();
        evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NS-1:0] one;
        logic [NS-1:0] pat;
        logic [NS-1:0] msk;
        #1;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 status", 32'(status_o), 0);
        chk("R1 mask", 32'(mask_o), 32'((1 << NS) - 1));
        chk("R1 ctrl", 32'(ctrl_o), 0);
        chk("R1 pin", 32'(irq_pin), 0);
        chk("R1 oe", 32'(pins_oe), 1);

        wr(2'd0, '0);
        // R2 R3 R4 R7: every source alone
        for (int i = 0; i < NS; i++) begin
            one = NS'(1) << i;
            pulse(one);
            chk("R2 R3 set", 32'(status_o), 32'(one));
            tick();
            chk("R7 pin high", 32'(irq_pin), 1);
            chk("R2 sticky", 32'(status_o), 32'(one));
            wr(2'd1, ~one);
            chk("R4 zeros keep", 32'(status_o), 32'(one));
            wr(2'd1, one);
            chk("R4 clear", 32'(status_o), 0);
            tick();
            chk("R7 pin low", 32'(irq_pin), 0);
        end

        // R6 R8: masked source latches but keeps the pin low
        for (int i = 0; i < NS; i++) begin
            one = NS'(1) << i;
            wr(2'd0, one);
            pulse(one);
            chk("R6 latched", 32'(status_o), 32'(one));
            tick();
            chk("R8 blocked", 32'(irq_pin), 0);
            wr(2'd0, '0);
            chk("R7 unmask lag", 32'(irq_pin), 0);
            tick();
            chk("R7 unmask", 32'(irq_pin), 1);
            wr(2'd1, '1);
        end

        // R7 pattern sweep, expected pin computed arithmetically
        for (int k = 0; k < 48; k++) begin
            pat = NS'((k * 32'h2B5) ^ (k << 7));
            msk = NS'((k * 32'h1D3) ^ 32'h0F0F);
            wr(2'd0, msk);
            pulse(pat);
            chk("R6 pattern", 32'(status_o), 32'(pat));
            tick();
            chk("R7 pattern", 32'(irq_pin), 32'(|(pat & ~msk)));
            wr(2'd1, '1);
        end
        wr(2'd0, '0);
        tick();

        // R5 same-cycle event and clear
        pulse(NS'(24));
        evt = NS'(8);
        wr(2'd1, NS'(24));
        evt = '0;
        chk("R5 event wins", 32'(status_o), 8);

        // R9 R12 hold
        tick();
        chk("R7 before hold", 32'(irq_pin), 1);
        wr(2'd2, NS'(1));
        chk("R9 cleared at write", 32'(status_o), 0);
        chk("R9 pin low at write", 32'(irq_pin), 0);
        chk("R9 ctrl", 32'(ctrl_o), 1);
        pulse('1);
        chk("R9 events ignored", 32'(status_o), 0);
        tick();
        chk("R9 pin held low", 32'(irq_pin), 0);
        wr(2'd2, '0);
        tick();
        chk("R12 released low", 32'(irq_pin), 0);
        chk("R12 status empty", 32'(status_o), 0);
        pulse(NS'(2));
        chk("R12 relatch", 32'(status_o), 2);
        chk("R12 lag", 32'(irq_pin), 0);
        tick();
        chk("R12 rise", 32'(irq_pin), 1);

        // R11 spare address
        wr(2'd3, '1);
        chk("R11 mask", 32'(mask_o), 0);
        chk("R11 ctrl", 32'(ctrl_o), 0);
        chk("R11 status", 32'(status_o), 2);

        // R10 float
        sync_src = 1'b1;
        #1;
        chk("R10 sync follows", 32'(sync_out), 1);
        sync_src = 1'b0;
        #1;
        chk("R10 sync follows 0", 32'(sync_out), 0);
        wr(2'd2, NS'(2));
        chk("R10 oe off", 32'(pins_oe), 0);
        chk("R10 ctrl", 32'(ctrl_o), 2);
        chk("R10 status kept", 32'(status_o), 2);
        wr(2'd2, '0);
        chk("R10 oe back", 32'(pins_oe), 1);
        tick();
        chk("R10 pin back", 32'(irq_pin), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule